// File: doc/BRIEF.md
# Identifier Search Master

This block is the master side of a single pass of the identifier search on a wired-AND, multi-drop bus. Each attached node holds a 64-bit identifier. The block walks through the identifier one bit position at a time, starting at bit 0. At each position it reads two slots, the node bit and then its inverse, and classifies the pair in one of three ways. If the reads differ, every remaining node agrees on that bit. If both reads are 0, remaining nodes disagree. If both reads are 1, no node is answering. The block then writes a direction bit. Every node whose bit differs from the direction drops out until the next bus reset.

After all positions have been handled, one node remains. The block presents that node's identifier on `id_out`. Between passes it keeps the last position where a disagreement was settled by choosing 0. The next pass uses that position to steer toward a different branch. Software repeats passes until `last_device` comes back set. Each bus slot is requested from a separate slot engine through a request/acknowledge handshake. Bus reset generation and CRC checking of the result are handled outside this block.

Top module: `rom_search_master`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `slot_req`, `no_device` and `last_device` are all 0, and no slot is requested while idle.
- R2: For each position the block issues three slots in a fixed order: a read of the bit, a read of the inverse, and a write. `slot_wr` is 0 for the two reads and 1 for the write. Each request holds `slot_req`, `slot_wr` and `slot_wbit` steady until the cycle in which `slot_ack` is 1, and `slot_rbit` is taken in that cycle.
- R3: When the two reads at a position differ, the written direction equals the first read (the bit value).
- R4: When both reads at a position are 1, the pass ends with no write for that position. `done` pulses with `no_device` = 1 and `last_device` = 0, no further slot is requested, and the next pass starts a fresh search.
- R5: When both reads are 0, the direction depends on the stored position from the previous pass. Positions are numbered 1 to 64, with bit 0 as position 1. Below the stored position the direction repeats the previous pass's bit. At the stored position the direction is 1. Above it, or when nothing is stored, the direction is 0.
- R6: During a pass the block records the highest position at which a disagreement was settled with direction 0. At the end of the pass, that record replaces the stored position.
- R7: A pass ends after the 64th write. `id_out` then holds the written directions, bit k being the direction written at bit k, and exactly one node remains active.
- R8: `last_device` is 1 at the end of a pass in which no disagreement was settled with 0. The next pass then starts a fresh search.
- R9: On a bus with several nodes, repeated passes return every node's identifier exactly once, ending with `last_device` = 1 on the final one.
- R10: `busy` is high from the cycle after `start` until the pass ends. `done` is a one-cycle pulse, and `no_device` and `last_device` are held until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass when idle |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when a pass ends |
| last_device | output | 1 | No further node remains to be found |
| no_device | output | 1 | Pass aborted: no node answered |
| id_out | output | ID_W | Identifier found by the last completed pass |
| slot_req | output | 1 | Slot request to the slot engine |
| slot_wr | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit to write in a write slot |
| slot_ack | input | 1 | Slot engine completed the current slot |
| slot_rbit | input | 1 | Bus value sampled in a read slot |

## Verification
Several properties are checked by assertions on every cycle:
- the slot request stays quiet while idle and holds steady until acknowledged;
- an agreeing pair always yields a write equal to the bit read;
- `done` lasts one cycle;
- `no_device` is raised only together with `done`, and never together with `last_device`.

The conflict steering, the carry-over of the disagreement position between passes and complete enumeration can only be shown by the bench. It pairs the block with modelled nodes and checks the exact order of identifiers in a crafted three-node case. It also checks that a five-node set containing all-zero, all-one and top-bit-only identifiers is returned once each.

// File: rtl/rom_search_master.sv
module rom_search_master #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            last_device,
  output logic            no_device,
  output logic [ID_W-1:0] id_out,
  output logic            slot_req,
  output logic            slot_wr,
  output logic            slot_wbit,
  input  logic            slot_ack,
  input  logic            slot_rbit
);
  localparam int IW = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam int PW = $clog2(ID_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RB, ST_RC, ST_WR} st_t;

  st_t             st_q;
  logic [IW-1:0]   idx_q;
  logic [ID_W-1:0] id_q;
  logic            bit_q, cmp_q;
  logic [PW-1:0]   ldisc_q, lzero_q;
  logic            done_q, nodev_q, lastdev_q;

  logic [PW-1:0] pos1;
  logic          conflict, conf_dir, dir, last_pos;

  assign pos1     = PW'(idx_q) + PW'(1);
  assign conflict = ~bit_q & ~slot_rbit;
  assign conf_dir = (pos1 < ldisc_q) ? id_q[idx_q] : (pos1 == ldisc_q);
  assign dir      = conflict ? conf_dir : bit_q;
  assign last_pos = (idx_q == IW'(ID_W - 1));

  assign busy        = (st_q != ST_IDLE);
  assign slot_req    = busy;
  assign slot_wr     = (st_q == ST_WR);
  assign slot_wbit   = slot_wr & id_q[idx_q];
  assign done        = done_q;
  assign no_device   = nodev_q;
  assign last_device = lastdev_q;
  assign id_out      = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      id_q      <= '0;
      bit_q     <= 1'b0;
      cmp_q     <= 1'b0;
      ldisc_q   <= '0;
      lzero_q   <= '0;
      done_q    <= 1'b0;
      nodev_q   <= 1'b0;
      lastdev_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_RB;
          idx_q     <= '0;
          lzero_q   <= '0;
          nodev_q   <= 1'b0;
          lastdev_q <= 1'b0;
        end
        ST_RB: if (slot_ack) begin
          bit_q <= slot_rbit;
          st_q  <= ST_RC;
        end
        ST_RC: if (slot_ack) begin
          cmp_q <= slot_rbit;
          if (bit_q & slot_rbit) begin
            st_q    <= ST_IDLE;
            nodev_q <= 1'b1;
            done_q  <= 1'b1;
            ldisc_q <= '0;
          end else begin
            id_q[idx_q] <= dir;
            if (conflict && !dir) lzero_q <= pos1;
            st_q <= ST_WR;
          end
        end
        ST_WR: if (slot_ack) begin
          if (last_pos) begin
            st_q      <= ST_IDLE;
            done_q    <= 1'b1;
            lastdev_q <= (lzero_q == '0);
            ldisc_q   <= lzero_q;
          end else begin
            idx_q <= idx_q + IW'(1);
            st_q  <= ST_RB;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/search_master_chk.sv
module search_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic no_device,
  input logic last_device,
  input logic slot_req,
  input logic slot_wr,
  input logic slot_wbit,
  input logic slot_ack,
  input logic b_q,
  input logic c_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wr) && $stable(slot_wbit)));

  // R3
  agree_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && (b_q != c_q)) |-> (slot_wbit == b_q));

  // R4
  abort_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_device) |-> (done && !busy));

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(no_device && last_device));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rom_search_master search_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .no_device   (no_device),
  .last_device (last_device),
  .slot_req    (slot_req),
  .slot_wr     (slot_wr),
  .slot_wbit   (slot_wbit),
  .slot_ack    (slot_ack),
  .b_q         (bit_q),
  .c_q         (cmp_q)
);

// File: tb/test_rom_search_master.sv
`timescale 1ns/1ps
module test_rom_search_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, last_device, no_device;
  logic [63:0] id_out;
  logic slot_req, slot_wr, slot_wbit;
  logic slot_ack = 1'b0;
  logic slot_rbit = 1'b0;

  always #2.5 clk = ~clk;

  rom_search_master #(.ID_W(64)) i_rom_search_master (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .last_device(last_device), .no_device(no_device), .id_out(id_out),
    .slot_req(slot_req), .slot_wr(slot_wr), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit)
  );

  int nchk = 0, nfail = 0;
  logic [63:0] nid [8];
  bit act [8];
  int nn = 0;
  int pos, phase, nwr, wr_err, nact;
  logic [63:0] written;
  logic [63:0] r_id;
  bit r_done, r_last, r_nodev, r_done_after;

  task automatic chk(bit ok, string tag, logic [63:0] a, logic [63:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic bus_val();
    logic v = 1'b1;
    for (int k = 0; k < nn; k++)
      if (act[k]) v &= (phase == 0) ? nid[k][pos] : ~nid[k][pos];
    return v;
  endfunction

  task automatic run_pass();
    int cyc = 0;
    int wn = 0;
    bit fin = 0;
    for (int k = 0; k < 8; k++) act[k] = (k < nn);
    pos = 0; phase = 0; nwr = 0; wr_err = 0; written = '0; r_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin) begin
      slot_ack = 1'b0;
      if (done) begin
        fin = 1; r_done = 1;
      end else if (cyc > 3000) begin
        chk(0, "R10 pass timeout", 64'(cyc), 64'd3000);
        fin = 1;
      end else if (slot_req && pos < 64) begin
        if (wn < (pos + phase) % 3) wn++;
        else begin
          wn = 0;
          if (phase < 2) begin
            if (slot_wr) wr_err++;
            slot_rbit = bus_val();
            phase++;
          end else begin
            if (!slot_wr) wr_err++;
            for (int k = 0; k < nn; k++)
              if (act[k] && nid[k][pos] != slot_wbit) act[k] = 0;
            written[pos] = slot_wbit;
            nwr++; pos++; phase = 0;
          end
          slot_ack = 1'b1;
        end
      end
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    r_id = id_out; r_last = last_device; r_nodev = no_device;
    nact = 0;
    for (int k = 0; k < nn; k++) if (act[k]) nact++;
    @(negedge clk);
    r_done_after = done;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !slot_req, "R1 idle outputs", {61'd0, busy, done, slot_req}, 64'd0);
    chk(!no_device && !last_device, "R1 flags", {62'd0, no_device, last_device}, 64'd0);
  endtask

  task automatic t_single();
    nn = 1; nid[0] = 64'h3A00_0123_4567_89FD;
    run_pass();
    chk(r_done && !r_done_after, "R10 done pulse", {62'd0, r_done, r_done_after}, 64'd2);
    chk(nwr == 64 && wr_err == 0, "R2 slot order", 64'(nwr + 1000 * wr_err), 64'd64);
    chk(r_id == nid[0], "R3 agreeing bits", r_id, nid[0]);
    chk(r_id == written && nact == 1, "R7 assembled id", written, r_id);
    chk(r_last && !r_nodev, "R8 single node last", {62'd0, r_last, r_nodev}, 64'd2);
  endtask

  task automatic t_order3();
    logic [63:0] base = 64'h5555_0000_AAAA_1230;
    nn = 3;
    nid[0] = base;
    nid[1] = base | 64'h80;
    nid[2] = base | 64'h04;
    run_pass();
    chk(r_id == nid[0] && !r_last, "R5 first pass zeros", r_id, nid[0]);
    run_pass();
    chk(r_id == nid[1] && !r_last, "R6 second pass", r_id, nid[1]);
    run_pass();
    chk(r_id == nid[2] && r_last, "R5 third pass", r_id, nid[2]);
    chk(nact == 1 && wr_err == 0, "R7 one node left", 64'(nact), 64'd1);
    run_pass();
    chk(r_id == nid[0] && !r_last, "R8 fresh after last", r_id, nid[0]);
  endtask

  task automatic t_none();
    nn = 0;
    run_pass();
    chk(r_done && r_nodev && !r_last, "R4 abort flags", {61'd0, r_done, r_nodev, r_last}, 64'd6);
    chk(nwr == 0 && phase == 2, "R4 no write", 64'(nwr * 10 + phase), 64'd2);
    repeat (4) @(negedge clk);
    chk(!slot_req && !busy && no_device, "R10 flags held idle", {61'd0, slot_req, busy, no_device}, 64'd1);
  endtask

  task automatic t_enum();
    bit found [8];
    int nfound = 0;
    int last_at = 0;
    nn = 5;
    nid[0] = 64'h0;
    nid[1] = '1;
    nid[2] = 64'h8000_0000_0000_0000;
    nid[3] = 64'h1;
    nid[4] = 64'hC3E1_0F00_1234_56FD;
    for (int k = 0; k < 8; k++) found[k] = 0;
    for (int p = 1; p <= 7 && last_at == 0; p++) begin
      int hit = -1;
      run_pass();
      for (int k = 0; k < nn; k++) if (nid[k] == r_id) hit = k;
      chk(hit >= 0 && !found[hit] && !r_nodev, "R9 new identifier", r_id, (hit >= 0) ? nid[hit] : 64'hX);
      if (hit >= 0 && !found[hit]) begin found[hit] = 1; nfound++; end
      if (r_last) last_at = p;
    end
    chk(nfound == 5, "R9 all found", 64'(nfound), 64'd5);
    chk(last_at == 5, "R8 last on final pass", 64'(last_at), 64'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order3();
    t_none();
    t_enum();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule